// File: doc/BRIEF.md
# Run-Time Selectable Serial CRC Engine

This block computes a cyclic redundancy code one bit per clock. A linear feedback shift register divides the incoming bit stream by one of four generator polynomials, using modulo-2 arithmetic. The polynomial is chosen at run time. The same register serves two jobs, selected per frame.

In generate mode, the block absorbs a data stream of any length. Once the last data bit is in, it emits the remainder as a frame check sequence. In check mode, the block absorbs a whole received frame, data first and then its check sequence. It reports whether the remainder of that frame is non-zero.

Both the data input and the check-sequence output are valid/ready streams:
- A transfer happens on any rising edge where valid and ready are both high.
- The input drops `in_ready` for as long as a check sequence is waiting to leave.
- The output holds `fcs_bit` and `fcs_last` steady while `fcs_ready` is low.

The selects and the check-result flags are plain level signals.

Top module: `crc_serial_engine`

## Requirements
- R1: `poly_sel` picks the divisor, and the check sequence width w follows from it:
  - code 0: x^12+x^11+x^3+x^2+x+1 (w=12)
  - code 1: x^16+x^15+x^2+1 (w=16)
  - code 2: x^16+x^12+x^5+1 (w=16)
  - code 3: x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1 (w=32)

  In generate mode (`chk_mode`=0), the emitted check sequence equals the remainder of the data polynomial times x^w divided by the selected divisor. The first data bit is the highest-order coefficient.
- R2: After the data bit flagged by `in_eod` is accepted in generate mode, the block emits exactly w check bits on `fcs_bit`, most significant first. `fcs_last` is high on the final one. While `fcs_ready` is low, `fcs_valid` and `fcs_bit` hold.
- R3: `in_ready` is low from the cycle after the generate-mode end-of-data bit is accepted until the last check bit has been taken. It is high again on the following cycle.
- R4: In check mode (`chk_mode`=1), a frame that consists of data followed by its correct check sequence gives `chk_err`=0.
- R5: In check mode, any frame that differs from a correct one in a single bit, or in a burst of at most w bits, gives `chk_err`=1.
- R6: `chk_valid` is low after a start-of-frame bit is accepted. It goes high in the cycle after the check-mode bit flagged by `in_eod` is accepted. `chk_valid` and `chk_err` then hold until the next accepted start-of-frame bit.
- R7: `poly_sel` and `chk_mode` are sampled only with an accepted `in_sof` bit. Changing them at any other time has no effect on the frame in progress or on its check sequence.
- R8: An accepted `in_sof` bit clears the register before that bit is absorbed. A frame abandoned without `in_eod` has no effect on the next frame's result.
- R9: During and directly after reset, `in_ready`=1, `fcs_valid`=0 and `chk_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Block can accept an input bit |
| in_bit | input | 1 | Serial data or frame bit |
| in_sof | input | 1 | This bit starts a frame |
| in_eod | input | 1 | This bit is the last data bit (generate) or last frame bit (check) |
| poly_sel | input | 2 | Divisor code, sampled with start of frame |
| chk_mode | input | 1 | 0 generate, 1 check; sampled with start of frame |
| fcs_valid | output | 1 | Check-sequence bit is offered |
| fcs_ready | input | 1 | Consumer takes the offered check bit |
| fcs_bit | output | 1 | Serial check-sequence bit, MSB first |
| fcs_last | output | 1 | Offered check bit is the final one |
| chk_valid | output | 1 | Check result is valid |
| chk_err | output | 1 | Received frame has a non-zero remainder |

## Verification
The bench targets the corner cases where a CRC design usually goes wrong, and each one has a visible symptom:
- **One-bit frames that start and end on the same bit.** A design that mishandles them would either skip the register clear or miss the end.
- **Changing selects mid-frame.** A design that lets `poly_sel` through outside the start of frame would produce a check sequence of the wrong width or value.
- **Back-pressure while the check sequence shifts out.** A design that shifts on `fcs_valid` alone would drop bits, or repeat `fcs_last` at the wrong place.
- **Abandoned frames.** An abandoned frame left uncleared would corrupt the next remainder.
- **Single flips and bursts up to the full register width, in all four polynomials.** A wrong tap would pass one of them unflagged.

// File: rtl/crc_sel_pkg.sv
package crc_sel_pkg;
  localparam int MAXW = 32;
  localparam int IW   = $clog2(MAXW);

  typedef enum logic [1:0] {
    POLY_C12  = 2'd0,
    POLY_C16A = 2'd1,
    POLY_C16B = 2'd2,
    POLY_C32  = 2'd3
  } poly_e;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } mode_e;
endpackage

// File: rtl/crc_poly_table.sv
module crc_poly_table
  import crc_sel_pkg::*;
(
  input  poly_e            sel,
  output logic [MAXW-1:0]  taps,
  output logic [MAXW-1:0]  mask,
  output logic [IW-1:0]    msb_idx
);
  // taps omit the leading x^w term; msb_idx is w-1
  always_comb begin
    case (sel)
      POLY_C12: begin
        taps    = MAXW'(32'h0000_080F);
        mask    = MAXW'(32'h0000_0FFF);
        msb_idx = IW'(11);
      end
      POLY_C16A: begin
        taps    = MAXW'(32'h0000_8005);
        mask    = MAXW'(32'h0000_FFFF);
        msb_idx = IW'(15);
      end
      POLY_C16B: begin
        taps    = MAXW'(32'h0000_1021);
        mask    = MAXW'(32'h0000_FFFF);
        msb_idx = IW'(15);
      end
      default: begin
        taps    = MAXW'(32'h04C1_1DB7);
        mask    = MAXW'(32'hFFFF_FFFF);
        msb_idx = IW'(31);
      end
    endcase
  end
endmodule

// File: rtl/crc_lfsr.sv
module crc_lfsr
  import crc_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dat_en,
  input  logic             din,
  input  logic             sft_en,
  input  logic [MAXW-1:0]  taps,
  input  logic [MAXW-1:0]  mask,
  input  logic [IW-1:0]    msb_idx,
  output logic [MAXW-1:0]  rem_q,
  output logic [MAXW-1:0]  rem_d,
  output logic             rem_msb
);
  logic [MAXW-1:0] base;
  logic [MAXW-1:0] sft_nxt;
  logic            fb;

  always_comb begin
    base    = clr ? '0 : rem_q;
    fb      = base[msb_idx] ^ din;
    rem_d   = ((base << 1) ^ (fb ? taps : '0)) & mask;
    sft_nxt = (rem_q << 1) & mask;
    rem_msb = rem_q[msb_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (dat_en) rem_q <= rem_d;
    else if (sft_en) rem_q <= sft_nxt;
  end

  // R1: no bits above the active width survive once the frame is set up
  p_upper_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> ((rem_q & ~mask) == '0));
endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_sel_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_sof,
  input  logic           in_eod,
  input  mode_e          mode_eff,
  input  logic           fcs_ready,
  input  logic [IW-1:0]  msb_idx,
  input  logic           rem_nz,
  output logic           in_ready,
  output logic           acc,
  output logic           fcs_valid,
  output logic           fcs_last,
  output logic           sft_en,
  output logic           chk_valid,
  output logic           chk_err
);
  typedef enum logic {ST_DATA, ST_FCS} st_e;
  st_e           state;
  logic [IW-1:0] cnt;

  always_comb begin
    in_ready  = (state == ST_DATA);
    acc       = in_valid & in_ready;
    fcs_valid = (state == ST_FCS);
    fcs_last  = fcs_valid && (cnt == msb_idx);
    sft_en    = fcs_valid & fcs_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_DATA;
      cnt       <= '0;
      chk_valid <= 1'b0;
      chk_err   <= 1'b0;
    end else begin
      if (acc) begin
        if (in_sof) begin
          chk_valid <= 1'b0;
          chk_err   <= 1'b0;
        end
        if (in_eod) begin
          if (mode_eff == MODE_GEN) begin
            state <= ST_FCS;
            cnt   <= '0;
          end else begin
            chk_valid <= 1'b1;
            chk_err   <= rem_nz;
          end
        end
      end
      if (sft_en) begin
        if (fcs_last) state <= ST_DATA;
        else          cnt   <= cnt + 1'b1;
      end
    end
  end

  // R3: end of data in generate mode blocks the input on the next cycle
  p_eod_blocks_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_eod && mode_eff == MODE_GEN) |=> (fcs_valid && !in_ready));

  // R2: a stalled check bit keeps its position in the sequence
  p_fcs_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_valid && !fcs_ready) |=> (fcs_valid && $stable(cnt)));

  // R2: the bit counter never passes the final position
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_valid |-> (cnt <= msb_idx));

  // R6: the check result holds until the next accepted start of frame
  p_chk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !(acc && in_sof)) |=> (chk_valid && $stable(chk_err)));
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_sof,
  input  logic       in_eod,
  input  logic [1:0] poly_sel,
  input  logic       chk_mode,
  output logic       fcs_valid,
  input  logic       fcs_ready,
  output logic       fcs_bit,
  output logic       fcs_last,
  output logic       chk_valid,
  output logic       chk_err
);
  poly_e           sel_q, sel_eff;
  mode_e           mode_q, mode_eff;
  logic            acc, start, sft_en;
  logic [MAXW-1:0] taps, mask, rem_q, rem_d;
  logic [IW-1:0]   msb_idx;
  logic            rem_msb;

  assign start    = acc & in_sof;
  assign sel_eff  = start ? poly_e'(poly_sel) : sel_q;
  assign mode_eff = start ? mode_e'(chk_mode) : mode_q;
  assign fcs_bit  = rem_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= POLY_C12;
      mode_q <= MODE_GEN;
    end else if (start) begin
      sel_q  <= poly_e'(poly_sel);
      mode_q <= mode_e'(chk_mode);
    end
  end

  crc_poly_table u_table (
    .sel     (sel_eff),
    .taps    (taps),
    .mask    (mask),
    .msb_idx (msb_idx)
  );

  crc_lfsr u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .dat_en  (acc),
    .din     (in_bit),
    .sft_en  (sft_en),
    .taps    (taps),
    .mask    (mask),
    .msb_idx (msb_idx),
    .rem_q   (rem_q),
    .rem_d   (rem_d),
    .rem_msb (rem_msb)
  );

  crc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eod    (in_eod),
    .mode_eff  (mode_eff),
    .fcs_ready (fcs_ready),
    .msb_idx   (msb_idx),
    .rem_nz    (|rem_d),
    .in_ready  (in_ready),
    .acc       (acc),
    .fcs_valid (fcs_valid),
    .fcs_last  (fcs_last),
    .sft_en    (sft_en),
    .chk_valid (chk_valid),
    .chk_err   (chk_err)
  );

  // R7: the selects are held for the whole frame
  p_sel_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(sel_q) && $stable(mode_q)));

  // R2: the offered check bit does not move while stalled
  p_fcs_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_valid && !fcs_ready) |=> ($stable(fcs_bit) && $stable(fcs_last)));
endmodule

// File: tb/crc_serial_engine_tb_top.sv
module crc_serial_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_bit, in_sof, in_eod;
  logic [1:0] poly_sel;
  logic chk_mode;
  logic fcs_valid, fcs_ready, fcs_bit, fcs_last, chk_valid, chk_err;

  int checks = 0;
  int errs   = 0;
  bit dbuf [0:255];
  bit gbuf [0:255];
  bit fbuf [0:255];

  always #2 clk = ~clk;

  crc_serial_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sof(in_sof), .in_eod(in_eod), .poly_sel(poly_sel),
    .chk_mode(chk_mode), .fcs_valid(fcs_valid), .fcs_ready(fcs_ready),
    .fcs_bit(fcs_bit), .fcs_last(fcs_last), .chk_valid(chk_valid),
    .chk_err(chk_err)
  );

  function automatic int wid(int s);
    case (s)
      0: return 12;
      1, 2: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [32:0] full_poly(int s);
    case (s)
      0: return 33'h0_0000_180F;
      1: return 33'h0_0001_8005;
      2: return 33'h0_0001_1021;
      default: return 33'h1_04C1_1DB7;
    endcase
  endfunction

  // textbook long division of data * x^w by the full divisor
  function automatic logic [31:0] ref_rem(int s, int n);
    logic [32:0] r;
    logic [32:0] p;
    int w;
    r = '0;
    p = full_poly(s);
    w = wid(s);
    for (int i = 0; i < n + w; i++) begin
      r = {r[31:0], (i < n) ? dbuf[i] : 1'b0};
      if (r[w]) r = r ^ p;
    end
    return r[31:0];
  endfunction

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(bit b, bit s, bit e, int sel, bit md);
    @(negedge clk);
    if ($urandom_range(3) == 0) @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_sof = s; in_eod = e;
    if (s) begin
      poly_sel = 2'(sel); chk_mode = md;
    end else begin
      poly_sel = 2'($urandom); chk_mode = 1'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eod = 1'b0;
  endtask

  // generate mode over dbuf[0..n-1]; leaves data+fcs in gbuf
  task automatic gen_frame(int s, int n);
    int w, k, lastbad, rdybad, stallbad;
    bit rdy, prev_stall, prev_bit;
    logic [31:0] got;
    w = wid(s); k = 0; lastbad = 0; rdybad = 0; stallbad = 0;
    got = '0; prev_stall = 1'b0; prev_bit = 1'b0;
    for (int i = 0; i < n; i++) push(dbuf[i], i == 0, i == n - 1, s, 1'b0);
    expect_eq("R3 in_ready low after end of data", {31'd0, in_ready}, 32'd0);
    while (k < w) begin
      rdy = ($urandom_range(2) != 0);
      fcs_ready = rdy;
      poly_sel = 2'($urandom); chk_mode = 1'($urandom);
      if (prev_stall && fcs_bit !== prev_bit) stallbad++;
      prev_stall = fcs_valid && !rdy;
      prev_bit = fcs_bit;
      if (fcs_valid && rdy) begin
        got = {got[30:0], fcs_bit};
        if (fcs_last !== (k == w - 1)) lastbad++;
        k++;
      end
      if (in_ready) rdybad++;
      @(negedge clk);
    end
    fcs_ready = 1'b0;
    expect_eq($sformatf("R1 fcs sel=%0d n=%0d", s, n), got, ref_rem(s, n));
    expect_eq("R2 fcs_last placement", lastbad, 0);
    expect_eq("R2 bit held under stall", stallbad, 0);
    expect_eq("R3 no input during fcs", rdybad, 0);
    expect_eq("R3 in_ready back", {30'd0, in_ready, fcs_valid}, 32'd2);
    for (int i = 0; i < n; i++) gbuf[i] = dbuf[i];
    for (int i = 0; i < w; i++) gbuf[n + i] = got[w - 1 - i];
  endtask

  task automatic chk_frame(int s, int n, bit experr, string tag);
    for (int i = 0; i < n; i++) begin
      push(fbuf[i], i == 0, i == n - 1, s, 1'b1);
      if (i == 0 && n > 1)
        expect_eq("R6 chk_valid cleared by start", {31'd0, chk_valid}, 32'd0);
    end
    expect_eq({tag, " chk result"}, {30'd0, chk_valid, chk_err}, {30'd0, 1'b1, experr});
    repeat (3) begin
      poly_sel = 2'($urandom); chk_mode = 1'($urandom);
      @(negedge clk);
    end
    expect_eq("R6 result held", {30'd0, chk_valid, chk_err}, {30'd0, 1'b1, experr});
  endtask

  task automatic full_round(int s, int n);
    int w, tot, pos, len;
    w = wid(s);
    tot = n + w;
    gen_frame(s, n);
    for (int i = 0; i < tot; i++) fbuf[i] = gbuf[i];
    chk_frame(s, tot, 1'b0, "R4 clean frame");
    for (int i = 0; i < tot; i++) fbuf[i] = gbuf[i];
    pos = $urandom_range(tot - 1);
    fbuf[pos] = ~fbuf[pos];
    chk_frame(s, tot, 1'b1, "R5 single flip");
    for (int i = 0; i < tot; i++) fbuf[i] = gbuf[i];
    len = 1 + $urandom_range(((w < tot) ? w : tot) - 1);
    pos = $urandom_range(tot - len);
    fbuf[pos] = ~fbuf[pos];
    fbuf[pos + len - 1] = ~fbuf[pos + len - 1];
    if (len > 2) for (int i = pos + 1; i < pos + len - 1; i++) fbuf[i] ^= 1'($urandom);
    if (len == 2 || len == 1) ; // end flips define the burst
    if (len == 1) fbuf[pos] = ~gbuf[pos];
    chk_frame(s, tot, 1'b1, "R5 burst");
  endtask

  initial begin
    void'($urandom(32'd24680));
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; in_sof = 1'b0; in_eod = 1'b0;
    poly_sel = 2'd0; chk_mode = 1'b0; fcs_ready = 1'b0;
    repeat (4) @(negedge clk);
    expect_eq("R9 reset outputs", {29'd0, in_ready, fcs_valid, chk_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R9 after reset", {29'd0, in_ready, fcs_valid, chk_valid}, 32'd4);

    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 8; i++) dbuf[i] = 1'b0;
      full_round(s, 8);                 // R1 all-zero data gives zero fcs
      dbuf[0] = 1'b1;
      full_round(s, 1);                 // R1 one-bit frame, start and end together
    end

    // R8: abandoned generate frame followed by a fresh one
    for (int i = 0; i < 5; i++) push(1'b1, i == 0, 1'b0, 3, 1'b0);
    for (int i = 0; i < 20; i++) dbuf[i] = 1'($urandom);
    gen_frame(1, 20);
    // R8: abandoned check frame followed by a clean one
    for (int i = 0; i < 7; i++) push(1'b1, i == 0, 1'b0, 1, 1'b1);
    for (int i = 0; i < 36; i++) fbuf[i] = gbuf[i];
    chk_frame(1, 36, 1'b0, "R8 after abandoned frame");

    for (int it = 0; it < 40; it++) begin
      int s, n;
      s = $urandom_range(3);
      n = 1 + $urandom_range(99);
      for (int i = 0; i < n; i++) dbuf[i] = 1'($urandom);
      full_round(s, n);                 // R7 selects randomised mid-frame
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule